// File: doc/BRIEF.md
# Super I/O Configuration Port

This block gives a host a small configuration space through two adjacent byte addresses on an 8-bit I/O bus. The lower address is the index port and the one above it is the data port. The space starts locked. The host writes an unlock key to the index port, then selects a register by writing its index there and accesses that register through the data port. A second key locks the space again.

Inside the space there are two fixed identification registers, a logical-device selector, and a bank of per-device registers chosen by that selector. Each bank holds an enable bit and a 16-bit I/O base address. The enable bit and base address of one chosen device, the mailbox device, are driven out continuously so that a mailbox address decoder can use them.

Host software probes for the block by unlocking it, writing an index, and reading the index port back. Only an unlocked port echoes the index, so the echo shows which base address the block answers at.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, the device selector is 0, every device is disabled, and the mailbox device base address equals parameter MBX_RST_BASE (default 0x0A00) while `mbx_en` is 0.
- R2: While locked, writing 0x55 to the index port unlocks the space. While unlocked, writing 0xAA to the index port locks it.
- R3: While unlocked, a read of the index port returns the last index written. While locked, it returns 0xFF.
- R4: While locked, data-port writes have no effect and data-port reads return 0xFF. Index-port writes other than 0x55 leave the stored index unchanged.
- R5: Index 0x20 reads DEV_ID (default 0x4D) and index 0x21 reads DEV_REV (default 0x01). Writes to either register are discarded.
- R6: Index 0x07 is the 8-bit device selector and reads back the value written to it.
- R7: At index 0x30, bit 0 is the enable of the selected device and bits 7..1 read as 0. Each device keeps its own enable bit.
- R8: Indices 0x60 and 0x61 are the high and low bytes of the selected device's base address. Each device keeps its own address.
- R9: `mbx_en` and `mbx_base` always show the bank of device MBX_LDN (default 9), whatever device is selected. They change in the cycle after a data write to that bank.
- R10: Unimplemented indices, and banked indices while the selector is at or above NUM_LDN (default 16), read 0x00 and ignore writes.
- R11: Accesses to any address other than BASE_ADDR (default 0x002E) and BASE_ADDR+1 have no effect, and reads of them return 0x00. `io_rdata` is 0x00 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, data returned in the same cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| mbx_en | output | 1 | Enable bit of the mailbox device |
| mbx_base | output | 16 | I/O base address of the mailbox device |

## Verification
The space is exercised in both the locked and the unlocked state with the same accesses, so that a key decoder, an echo path or a write gate that ignores the lock shows up as a wrong read. Banked registers are written under one device number and read back under another, which separates true banking from a single shared register. A selector value past the bank count, an unimplemented index, and writes to the ID registers test the discard paths. Foreign addresses test the address decode. The mailbox outputs are checked after the selector has moved away from the mailbox device, and again after a second reset.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter logic [15:0] BASE_ADDR    = 16'h002E,
  parameter logic [7:0]  DEV_ID       = 8'h4D,
  parameter logic [7:0]  DEV_REV      = 8'h01,
  parameter int          NUM_LDN      = 16,
  parameter int          MBX_LDN      = 9,
  parameter logic [15:0] MBX_RST_BASE = 16'h0A00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        mbx_en,
  output logic [15:0] mbx_base
);
  localparam int          LW      = $clog2(NUM_LDN);
  localparam logic [8:0]  NUM9    = 9'(NUM_LDN);
  localparam logic [7:0]  KEY_ON  = 8'h55;
  localparam logic [7:0]  KEY_OFF = 8'hAA;
  localparam logic [7:0]  IX_SEL  = 8'h07;
  localparam logic [7:0]  IX_ID   = 8'h20;
  localparam logic [7:0]  IX_REV  = 8'h21;
  localparam logic [7:0]  IX_EN   = 8'h30;
  localparam logic [7:0]  IX_HI   = 8'h60;
  localparam logic [7:0]  IX_LO   = 8'h61;

  logic             unlocked;
  logic [7:0]       idx_q;
  logic [7:0]       sel_q;
  logic             en_q [NUM_LDN];
  logic [7:0]       hi_q [NUM_LDN];
  logic [7:0]       lo_q [NUM_LDN];

  wire hit_idx = (io_addr == BASE_ADDR);
  wire hit_dat = (io_addr == BASE_ADDR + 16'd1);
  wire sel_ok  = ({1'b0, sel_q} < NUM9);
  wire [LW-1:0] bank = sel_q[LW-1:0];
  wire dat_wr  = io_wr && hit_dat && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      idx_q    <= 8'h00;
      sel_q    <= 8'h00;
      for (int i = 0; i < NUM_LDN; i++) begin
        en_q[i] <= 1'b0;
        hi_q[i] <= (i == MBX_LDN) ? MBX_RST_BASE[15:8] : 8'h00;
        lo_q[i] <= (i == MBX_LDN) ? MBX_RST_BASE[7:0]  : 8'h00;
      end
    end else begin
      if (io_wr && hit_idx) begin
        if (!unlocked) begin
          if (io_wdata == KEY_ON) unlocked <= 1'b1;
        end else if (io_wdata == KEY_OFF) begin
          unlocked <= 1'b0;
        end else begin
          idx_q <= io_wdata;
        end
      end
      if (dat_wr) begin
        if (idx_q == IX_SEL) sel_q <= io_wdata;
        if (sel_ok) begin
          if (idx_q == IX_EN) en_q[bank] <= io_wdata[0];
          if (idx_q == IX_HI) hi_q[bank] <= io_wdata;
          if (idx_q == IX_LO) lo_q[bank] <= io_wdata;
        end
      end
    end
  end

  logic [7:0] reg_val;
  always_comb begin
    reg_val = 8'h00;
    case (idx_q)
      IX_SEL: reg_val = sel_q;
      IX_ID:  reg_val = DEV_ID;
      IX_REV: reg_val = DEV_REV;
      IX_EN:  if (sel_ok) reg_val = {7'b0, en_q[bank]};
      IX_HI:  if (sel_ok) reg_val = hi_q[bank];
      IX_LO:  if (sel_ok) reg_val = lo_q[bank];
      default: reg_val = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (hit_idx)      io_rdata = unlocked ? idx_q : 8'hFF;
      else if (hit_dat) io_rdata = unlocked ? reg_val : 8'hFF;
    end
  end

  assign mbx_en   = en_q[MBX_LDN];
  assign mbx_base = {hi_q[MBX_LDN], lo_q[MBX_LDN]};
endmodule

module sio_cfg_port_chk #(
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter logic [7:0]  DEV_ID    = 8'h4D
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        mbx_en,
  input logic [15:0] mbx_base,
  input logic        unlocked,
  input logic [7:0]  idx_q
);
  wire at_idx = (io_addr == BASE_ADDR);
  wire at_dat = (io_addr == BASE_ADDR + 16'd1);

  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_idx && io_wdata == 8'h55 && !unlocked) |=> unlocked);
  assert_lock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_idx && io_wdata == 8'hAA && unlocked) |=> !unlocked);
  assert_index_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_idx && !unlocked) |-> io_rdata == 8'hFF);
  assert_locked_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && !unlocked) |-> io_rdata == 8'hFF);
  assert_id_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && unlocked && idx_q == 8'h20) |-> io_rdata == DEV_ID);
  assert_mbx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat && unlocked) |=> ($stable(mbx_base) && $stable(mbx_en)));
  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.BASE_ADDR(BASE_ADDR), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .mbx_en(mbx_en), .mbx_base(mbx_base),
  .unlocked(unlocked), .idx_q(idx_q)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam int CLK_P = 10;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam int NV = 44;
  // entry: {read, port(1=data), wdata, expect, req}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00,8'hFF,4'd3},  // R3 locked index hidden
    {1'b1,1'b1,8'h00,8'hFF,4'd4},  // R4 locked data read
    {1'b0,1'b0,8'h20,8'h00,4'd4},  // R4 index write ignored while locked
    {1'b0,1'b1,8'h12,8'h00,4'd4},
    {1'b0,1'b0,8'h55,8'h00,4'd2},  // R2 unlock
    {1'b1,1'b0,8'h00,8'h00,4'd4},  // index stayed 0
    {1'b0,1'b0,8'h20,8'h00,4'd3},
    {1'b1,1'b0,8'h00,8'h20,4'd3},  // R3 echo
    {1'b1,1'b1,8'h00,8'h4D,4'd5},  // R5 id
    {1'b0,1'b1,8'h99,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h4D,4'd5},
    {1'b0,1'b0,8'h21,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h01,4'd5},  // rev
    {1'b0,1'b0,8'h07,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h00,4'd6},  // R6 selector 0 after reset
    {1'b0,1'b1,8'h09,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h09,4'd6},
    {1'b0,1'b0,8'h30,8'h00,4'd7},
    {1'b0,1'b1,8'hFF,8'h00,4'd7},
    {1'b1,1'b1,8'h00,8'h01,4'd7},  // R7 upper bits zero
    {1'b0,1'b0,8'h60,8'h00,4'd8},
    {1'b0,1'b1,8'h12,8'h00,4'd8},
    {1'b0,1'b0,8'h61,8'h00,4'd8},
    {1'b0,1'b1,8'h34,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h34,4'd8},
    {1'b0,1'b0,8'h60,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h12,4'd8},
    {1'b0,1'b0,8'h07,8'h00,4'd7},
    {1'b0,1'b1,8'h03,8'h00,4'd7},
    {1'b0,1'b0,8'h30,8'h00,4'd7},
    {1'b1,1'b1,8'h00,8'h00,4'd7},  // R7 bank 3 separate
    {1'b0,1'b0,8'h60,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h00,4'd8},  // R8 bank 3 separate
    {1'b0,1'b0,8'h40,8'h00,4'd10},
    {1'b1,1'b1,8'h00,8'h00,4'd10}, // R10 unimplemented
    {1'b0,1'b1,8'h5A,8'h00,4'd10},
    {1'b1,1'b1,8'h00,8'h00,4'd10},
    {1'b0,1'b0,8'h07,8'h00,4'd10},
    {1'b0,1'b1,8'h20,8'h00,4'd10},
    {1'b0,1'b0,8'h30,8'h00,4'd10},
    {1'b0,1'b1,8'h01,8'h00,4'd10},
    {1'b1,1'b1,8'h00,8'h00,4'd10}, // selector out of range
    {1'b0,1'b0,8'hAA,8'h00,4'd2},  // R2 lock
    {1'b1,1'b0,8'h00,8'hFF,4'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        mbx_en;
  logic [15:0] mbx_base;
  int n_run = 0, n_fail = 0;

  sio_cfg_port u_dut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .mbx_en(mbx_en),
    .mbx_base(mbx_base));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1; io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string req, input logic [7:0] exp);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #(CLK_P/4); check(req, {8'h0, io_rdata}, {8'h0, exp});
    io_rd = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; repeat (3) @(posedge clk); #1; rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 en", {15'h0, mbx_en}, 16'h0000);
    check("R1 base", mbx_base, 16'h0A00);
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[21]) rd(v[20] ? DAT : IDX, $sformatf("R%0d vec%0d", v[3:0], i), v[11:4]);
      else wr(v[20] ? DAT : IDX, v[19:12]);
    end
    @(negedge clk);
    check("R9 en", {15'h0, mbx_en}, 16'h0001);
    check("R9 base", mbx_base, 16'h1234);
    wr(DAT, 8'h77);
    @(negedge clk);
    check("R4 locked write", mbx_base, 16'h1234);
    // R11 foreign addresses
    wr(16'h004E, 8'h55);
    rd(IDX, "R11 foreign key", 8'hFF);
    rd(16'h004E, "R11 foreign read", 8'h00);
    @(negedge clk); io_addr = IDX; #(CLK_P/4);
    check("R11 idle read", {8'h0, io_rdata}, 16'h0000);
    // R9 update timing
    wr(IDX, 8'h55); wr(IDX, 8'h07); wr(DAT, 8'h09); wr(IDX, 8'h61);
    @(negedge clk); io_addr = DAT; io_wdata = 8'hC3; io_wr = 1'b1;
    #1; check("R9 before edge", mbx_base, 16'h1234);
    @(posedge clk); #1; io_wr = 1'b0;
    check("R9 after edge", mbx_base, 16'h12C3);
    // R1 second reset
    do_reset();
    @(negedge clk);
    check("R1 en again", {15'h0, mbx_en}, 16'h0000);
    check("R1 base again", mbx_base, 16'h0A00);
    rd(IDX, "R1 locked after reset", 8'hFF);
    wr(IDX, 8'h55); wr(IDX, 8'h07);
    rd(DAT, "R1 selector zero", 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule